// File: doc/BRIEF.md
# UART Receive Buffer with Per-Character Error Tags

This block is the receive-side holding buffer of a serial port. The serial receiver pushes each finished character into it, together with four error tags that belong to that character alone. Software, or a DMA engine, takes characters from the head of the buffer in arrival order. It can also read the head's error status separately from the character.

The block reports four things about the buffer. A 4-bit occupancy field with a separate full flag gives the fill state. A buffer-ready flag shows that at least one character is waiting. A threshold request tracks a fill level picked by a 2-bit selection. A pending-error flag stays high while any stored character still carries error tags that have not been consumed.

A character that arrives while the buffer is full is thrown away, and the loss is recorded as an overrun tag on the newest stored character. A flush pulse empties the buffer in one cycle.

Top module: `uart_rx_err_fifo`

## Requirements
- R1: After reset, and in the cycle after a flush pulse, the count is 0 and full, buffer-ready, threshold request and pending-error are all low.
- R2: Characters appear on the head data output in the order they were written, and a pop advances to the next one.
- R3: Each stored character keeps its own 4-bit error tag, shown on the head error output alongside its data. The bit order is bit0 overrun, bit1 parity, bit2 framing and bit3 break. When the buffer is empty, head data and head error read 0.
- R4: The count output holds the number of stored characters modulo 16. The full flag is high exactly when 16 characters are stored, and the count then reads 0.
- R5: Buffer-ready is high whenever the count is nonzero or full is high.
- R6: The trigger selection maps 0, 1, 2 and 3 to levels of 4, 8, 12 and 16 characters. The threshold request is high while the stored number is at or above the selected level.
- R7: A write while full, with no pop in the same cycle, is dropped. It sets the overrun bit (bit0) of the newest stored character and leaves all other contents unchanged.
- R8: A pop while the buffer is empty has no effect, and a write in the same cycle is still stored.
- R9: The pending-error flag is high while any stored character has a nonzero error tag. An error-status read while the buffer is not empty clears the head character's tag to 0. The flag drops once the last tagged character has been read this way.
- R10: A write and a pop in the same cycle on a non-empty buffer leave the count unchanged. At full, the write is accepted.
- R11: Popping a tagged character removes its tag from the pending-error state, whether or not its error status was read first.
- R12: A flush takes priority over a write, a pop or an error-status read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Receiver delivers a character |
| wrData | input | 8 | Received character |
| wrOvr | input | 1 | Overrun tag for the character |
| wrPar | input | 1 | Parity error tag |
| wrFrm | input | 1 | Framing error tag |
| wrBrk | input | 1 | Break tag |
| popEn | input | 1 | Remove the head character |
| errRd | input | 1 | Error-status read of the head character |
| flush | input | 1 | Empty the buffer |
| trigSel | input | 2 | Threshold selection (0..3 gives 4, 8, 12, 16) |
| headData | output | 8 | Head character, 0 when empty |
| headErr | output | 4 | Head error tag, 0 when empty |
| count | output | 4 | Stored characters modulo 16 |
| full | output | 1 | 16 characters stored |
| bufReady | output | 1 | At least one character stored |
| trigReq | output | 1 | Fill level at or above the selected threshold |
| errPending | output | 1 | Some stored character carries an unread error tag |

## Verification
The functions that collide most often are a write and a pop in the same cycle, and an error-status read paired with the arrival of a new tagged character. The stimulus table drives these pairs on a partly filled buffer and on an empty one. Directed steps repeat the write-with-pop at full, right after a dropped write. Each collision is judged the cycle after it, from the count, the head character and its tag, and the pending-error flag. These values must show that both actions, or only the permitted one, took effect.

// File: rtl/uart_rx_err_fifo_pkg.sv
package uart_rx_err_fifo_pkg;

  localparam int ERR_W   = 4;
  localparam int OVR_BIT = 0;

  // Per-cycle commands from the control half to the storage half
  typedef struct packed {
    logic flush;
    logic pushAcc;
    logic popAcc;
    logic markOvr;
    logic clrHeadErr;
  } ctrlStrobes_t;

endpackage

// File: rtl/uart_rx_err_fifo_ctrl.sv
module uart_rx_err_fifo_ctrl
  import uart_rx_err_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrHasErr,
  input  logic             popEn,
  input  logic             errRd,
  input  logic             flush,
  input  logic [1:0]       trigSel,
  input  logic             headHasErr,
  input  logic             tailHasErr,
  output ctrlStrobes_t     strb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [PTR_W-1:0] tailPtr,
  output logic [CNT_W-1:0] occ,
  output logic             errPending,
  output logic             trigReq
);

  localparam int QUARTER = DEPTH / 4;

  logic [CNT_W-1:0] errCnt;
  logic             isEmpty;
  logic             isFull;
  logic             errInc;
  logic             errDec;
  int               trigLevel;

  assign isEmpty = (occ == '0);
  assign isFull  = (occ == CNT_W'(DEPTH));
  assign tailPtr = wrPtr - 1'b1;

  always_comb begin
    strb.flush      = flush;
    strb.popAcc     = popEn && !isEmpty && !flush;
    strb.pushAcc    = wrEn && !flush && (!isFull || strb.popAcc);
    strb.markOvr    = wrEn && !flush && isFull && !strb.popAcc;
    strb.clrHeadErr = errRd && !isEmpty && !flush;
  end

  assign errInc = (strb.pushAcc && wrHasErr) || (strb.markOvr && !tailHasErr);
  assign errDec = (strb.popAcc || strb.clrHeadErr) && headHasErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      occ    <= '0;
      errCnt <= '0;
    end else if (strb.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      occ    <= '0;
      errCnt <= '0;
    end else begin
      if (strb.pushAcc) wrPtr <= wrPtr + 1'b1;
      if (strb.popAcc)  rdPtr <= rdPtr + 1'b1;
      occ    <= occ + CNT_W'(strb.pushAcc) - CNT_W'(strb.popAcc);
      errCnt <= errCnt + CNT_W'(errInc) - CNT_W'(errDec);
    end
  end

  assign errPending = (errCnt != '0);

  always_comb begin
    trigLevel = (int'(trigSel) + 1) * QUARTER;
    trigReq   = (int'(occ) >= trigLevel);
  end

  // R1, R12: a flush empties the buffer and its error state
  p_flush_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (occ == '0) && !errPending);

  // R10: simultaneous write and pop keeps the fill level
  p_pushpop_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && popEn && !isEmpty && !flush) |=> $stable(occ));

  // R8: pop on empty without a write leaves it empty
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !wrEn && isEmpty && !flush) |=> (occ == '0));

  // R7: a dropped write keeps the buffer full and raises pending error
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isFull && !popEn && !flush) |=> (occ == CNT_W'(DEPTH)) && errPending);

  // R9: tagged entries never outnumber stored entries
  p_err_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= occ);

  // R4: fill level never exceeds the depth
  p_occ_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CNT_W'(DEPTH));

endmodule

// File: rtl/uart_rx_err_fifo_store.sv
module uart_rx_err_fifo_store
  import uart_rx_err_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [PTR_W-1:0]  tailPtr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ERR_W-1:0]  wrErr,
  output logic [DATA_W-1:0] headData,
  output logic [ERR_W-1:0]  headErr,
  output logic [ERR_W-1:0]  tailErr
);

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [ERR_W-1:0]  errMem  [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.pushAcc) dataMem[wrPtr] <= wrData;
  end

  // Error tags: head clear first, then overrun mark, then new write wins
  always_ff @(posedge clk) begin
    if (strb.clrHeadErr) errMem[rdPtr] <= '0;
    if (strb.markOvr)    errMem[tailPtr][OVR_BIT] <= 1'b1;
    if (strb.pushAcc)    errMem[wrPtr] <= wrErr;
  end

  assign headData = dataMem[rdPtr];
  assign headErr  = errMem[rdPtr];
  assign tailErr  = errMem[tailPtr];

  // R7: a dropped write marks overrun on the newest entry
  p_mark_ovr_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.markOvr |=> errMem[$past(tailPtr)][OVR_BIT]);

  // R9: an error-status read clears the head tag
  p_head_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrHeadErr && !strb.popAcc && !strb.pushAcc) |=> (errMem[$past(rdPtr)] == '0));

endmodule

// File: rtl/uart_rx_err_fifo.sv
module uart_rx_err_fifo
  import uart_rx_err_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrOvr,
  input  logic              wrPar,
  input  logic              wrFrm,
  input  logic              wrBrk,
  input  logic              popEn,
  input  logic              errRd,
  input  logic              flush,
  input  logic [1:0]        trigSel,
  output logic [DATA_W-1:0] headData,
  output logic [ERR_W-1:0]  headErr,
  output logic [PTR_W-1:0]  count,
  output logic              full,
  output logic              bufReady,
  output logic              trigReq,
  output logic              errPending
);

  ctrlStrobes_t      strb;
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  tailPtr;
  logic [CNT_W-1:0]  occ;
  logic [ERR_W-1:0]  wrErr;
  logic [DATA_W-1:0] rawData;
  logic [ERR_W-1:0]  rawErr;
  logic [ERR_W-1:0]  tailErr;

  assign wrErr = {wrBrk, wrFrm, wrPar, wrOvr};

  uart_rx_err_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrHasErr   (|wrErr),
    .popEn      (popEn),
    .errRd      (errRd),
    .flush      (flush),
    .trigSel    (trigSel),
    .headHasErr (|rawErr),
    .tailHasErr (|tailErr),
    .strb       (strb),
    .wrPtr      (wrPtr),
    .rdPtr      (rdPtr),
    .tailPtr    (tailPtr),
    .occ        (occ),
    .errPending (errPending),
    .trigReq    (trigReq)
  );

  uart_rx_err_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .tailPtr  (tailPtr),
    .wrData   (wrData),
    .wrErr    (wrErr),
    .headData (rawData),
    .headErr  (rawErr),
    .tailErr  (tailErr)
  );

  assign count    = occ[PTR_W-1:0];
  assign full     = occ[PTR_W];
  assign bufReady = (occ != '0);
  assign headData = bufReady ? rawData : '0;
  assign headErr  = bufReady ? rawErr  : '0;

  // R5: ready tracks count and full
  p_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    bufReady == ((count != '0) || full));

endmodule

// File: tb/uart_rx_err_fifo_tb_top.sv
module uart_rx_err_fifo_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrOvr = 1'b0, wrPar = 1'b0, wrFrm = 1'b0, wrBrk = 1'b0;
  logic       popEn = 1'b0, errRd = 1'b0, flush = 1'b0;
  logic [1:0] trigSel = '0;
  logic [7:0] headData;
  logic [3:0] headErr;
  logic [3:0] count;
  logic       full, bufReady, trigReq, errPending;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_rx_err_fifo dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .wrOvr(wrOvr), .wrPar(wrPar), .wrFrm(wrFrm), .wrBrk(wrBrk),
    .popEn(popEn), .errRd(errRd), .flush(flush), .trigSel(trigSel),
    .headData(headData), .headErr(headErr), .count(count), .full(full),
    .bufReady(bufReady), .trigReq(trigReq), .errPending(errPending)
  );

  // Vector: wr, data, err{brk,frm,par,ovr}, pop, errRd, flush, trigSel |
  //         expected count, full, ready, trig, pending, headData, headErr
  localparam int NV = 21;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1,8'hA1,4'h0,1'b0,1'b0,1'b0,2'd0, 4'd1,1'b0,1'b1,1'b0,1'b0,8'hA1,4'h0},
    {1'b1,8'hB2,4'h2,1'b0,1'b0,1'b0,2'd0, 4'd2,1'b0,1'b1,1'b0,1'b1,8'hA1,4'h0},
    {1'b1,8'hC3,4'h0,1'b0,1'b0,1'b0,2'd0, 4'd3,1'b0,1'b1,1'b0,1'b1,8'hA1,4'h0},
    {1'b1,8'hD4,4'h8,1'b0,1'b0,1'b0,2'd0, 4'd4,1'b0,1'b1,1'b1,1'b1,8'hA1,4'h0},
    {1'b0,8'h00,4'h0,1'b1,1'b0,1'b0,2'd0, 4'd3,1'b0,1'b1,1'b0,1'b1,8'hB2,4'h2},
    {1'b0,8'h00,4'h0,1'b0,1'b1,1'b0,2'd0, 4'd3,1'b0,1'b1,1'b0,1'b1,8'hB2,4'h0},
    {1'b1,8'hE5,4'h4,1'b1,1'b0,1'b0,2'd0, 4'd3,1'b0,1'b1,1'b0,1'b1,8'hC3,4'h0},
    {1'b0,8'h00,4'h0,1'b1,1'b0,1'b0,2'd0, 4'd2,1'b0,1'b1,1'b0,1'b1,8'hD4,4'h8},
    {1'b0,8'h00,4'h0,1'b1,1'b0,1'b0,2'd0, 4'd1,1'b0,1'b1,1'b0,1'b1,8'hE5,4'h4},
    {1'b0,8'h00,4'h0,1'b0,1'b1,1'b0,2'd1, 4'd1,1'b0,1'b1,1'b0,1'b0,8'hE5,4'h0},
    {1'b0,8'h00,4'h0,1'b1,1'b0,1'b0,2'd1, 4'd0,1'b0,1'b0,1'b0,1'b0,8'h00,4'h0},
    {1'b0,8'h00,4'h0,1'b1,1'b0,1'b0,2'd1, 4'd0,1'b0,1'b0,1'b0,1'b0,8'h00,4'h0},
    {1'b1,8'h5A,4'h1,1'b0,1'b1,1'b0,2'd0, 4'd1,1'b0,1'b1,1'b0,1'b1,8'h5A,4'h1},
    {1'b0,8'h00,4'h0,1'b1,1'b1,1'b0,2'd0, 4'd0,1'b0,1'b0,1'b0,1'b0,8'h00,4'h0},
    {1'b1,8'h11,4'h0,1'b1,1'b0,1'b0,2'd0, 4'd1,1'b0,1'b1,1'b0,1'b0,8'h11,4'h0},
    {1'b1,8'h22,4'h4,1'b1,1'b1,1'b1,2'd0, 4'd0,1'b0,1'b0,1'b0,1'b0,8'h00,4'h0},
    {1'b1,8'h33,4'h0,1'b0,1'b0,1'b0,2'd0, 4'd1,1'b0,1'b1,1'b0,1'b0,8'h33,4'h0},
    {1'b1,8'h44,4'h2,1'b0,1'b1,1'b0,2'd0, 4'd2,1'b0,1'b1,1'b0,1'b1,8'h33,4'h0},
    {1'b0,8'h00,4'h0,1'b1,1'b0,1'b0,2'd0, 4'd1,1'b0,1'b1,1'b0,1'b1,8'h44,4'h2},
    {1'b1,8'h66,4'h1,1'b0,1'b1,1'b0,2'd0, 4'd2,1'b0,1'b1,1'b0,1'b1,8'h44,4'h0},
    {1'b0,8'h00,4'h0,1'b0,1'b0,1'b1,2'd0, 4'd0,1'b0,1'b0,1'b0,1'b0,8'h00,4'h0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [7:0] d, input logic [3:0] e,
                       input logic p, input logic r, input logic f, input logic [1:0] t);
    wrEn = w; wrData = d; {wrBrk, wrFrm, wrPar, wrOvr} = e;
    popEn = p; errRd = r; flush = f; trigSel = t;
    @(posedge clk);
    #1;
    wrEn = 1'b0; popEn = 1'b0; errRd = 1'b0; flush = 1'b0;
  endtask

  task automatic chkAll(input string ctx, input int c, input logic fu, input logic rd,
                        input logic tr, input logic pe, input logic [7:0] hd, input logic [3:0] he);
    chk({ctx, " R4 count"}, int'(count), c);
    chk({ctx, " R4 full"}, int'(full), int'(fu));
    chk({ctx, " R5 ready"}, int'(bufReady), int'(rd));
    chk({ctx, " R6 trig"}, int'(trigReq), int'(tr));
    chk({ctx, " R9 pending"}, int'(errPending), int'(pe));
    chk({ctx, " R2 head data"}, int'(headData), int'(hd));
    chk({ctx, " R3 head err"}, int'(headErr), int'(he));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    chkAll("R1 reset", 0, 0, 0, 0, 0, 8'h00, 4'h0);
    rstN = 1'b1;
    @(posedge clk);
    #1;

    // Table walk: R2 R3 R6 R8 R9 R10 R11 R12 collisions included
    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      drive(v[37], v[36:29], v[28:25], v[24], v[23], v[22], v[21:20]);
      chkAll($sformatf("vec%0d", i), int'(v[19:16]), v[15], v[14], v[13], v[12], v[11:4], v[3:0]);
    end

    // Fill to 16 with threshold 16 (R4, R6)
    for (int i = 1; i <= 16; i++) begin
      drive(1'b1, 8'(i), 4'h0, 1'b0, 1'b0, 1'b0, 2'd3);
      if (i == 15) chkAll("fill15 R6", 15, 0, 1, 0, 0, 8'h01, 4'h0);
    end
    chkAll("full R4", 0, 1, 1, 1, 0, 8'h01, 4'h0);

    // Dropped write at full (R7): newest entry gets overrun
    drive(1'b1, 8'hEE, 4'h0, 1'b0, 1'b0, 1'b0, 2'd3);
    chkAll("drop R7", 0, 1, 1, 1, 1, 8'h01, 4'h0);

    // Write with pop at full is accepted (R10)
    drive(1'b1, 8'h77, 4'h0, 1'b1, 1'b0, 1'b0, 2'd3);
    chkAll("full pushpop R10", 0, 1, 1, 1, 1, 8'h02, 4'h0);

    // Drain with threshold 12; entry 0x10 holds the overrun tag (R7, R11)
    trigSel = 2'd2;
    for (int j = 2; j <= 16; j++) begin
      #1;
      chk("drain R2 head data", int'(headData), j);
      chk("drain R7 head err", int'(headErr), (j == 16) ? 1 : 0);
      chk("drain R6 trig sel2", int'(trigReq), ((18 - j) >= 12) ? 1 : 0);
      chk("drain R9 pending", int'(errPending), 1);
      drive(1'b0, 8'h00, 4'h0, 1'b1, 1'b0, 1'b0, 2'd2);
    end
    chkAll("after tagged pop R11", 1, 0, 1, 0, 0, 8'h77, 4'h0);
    drive(1'b0, 8'h00, 4'h0, 1'b1, 1'b0, 1'b0, 2'd2);
    chkAll("drained R8", 0, 0, 0, 0, 0, 8'h00, 4'h0);

    // Asynchronous reset mid-run (R1)
    drive(1'b1, 8'h99, 4'h8, 1'b0, 1'b0, 1'b0, 2'd0);
    drive(1'b1, 8'h98, 4'h0, 1'b0, 1'b0, 1'b0, 2'd0);
    rstN = 1'b0;
    #5;
    chkAll("R1 async reset", 0, 0, 0, 0, 0, 8'h00, 4'h0);
    rstN = 1'b1;
    @(posedge clk);
    #1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule